// File: doc/BRIEF.md
# GPIO Pad Bank with Per-Pad Register Groups

This block controls a parameterised bank of general-purpose pads. Each pad owns a fixed-size group of four 32-bit registers in a memory-mapped window. Through these registers software picks the pad's direction and output level, samples its input, stores a function-select field and chooses how the pad raises an interrupt. Interrupt status for the whole bank sits in a separate area as packed 32-pad words, which software reads and acknowledges in bulk.

The pad inputs come from outside the clock domain. Each one passes through a two-flop synchronizer before it is read or compared for edges. An edge trigger latches a status bit until software clears it. A level trigger makes the status bit follow the pad itself. One interrupt line merges the status of every pad that has a trigger armed. The register bus is a plain synchronous port and carries no flow control: a write takes effect on the clock edge where the write enable is high, and read data appears one cycle after the read enable. The pad lines are plain level signals.

Top module: `gpad_bank`

## Requirements
- R1: Pad p owns byte addresses p*16 .. p*16+15. The registers are: configuration A at +0x0, configuration B at +0x4, value at +0x8 and default at +0xC. Configuration B and default store and return all 32 bits. Configuration A keeps only bits 26 (falling trigger), 25 (rising trigger), 24 (level trigger) and 2:0 (function select), and returns every other bit as 0.
- R2: After reset, every value register reads 0x6 (input and output both disabled, level 0). Every configuration A reads 0, all status words read 0, and pad_oe, pad_out and irq are all 0.
- R3: pad_out[p] equals value bit 0. pad_oe[p] is 1 only when value bit 1 is 0 and the function select is 0.
- R4: Value bit 2 is an active-low input enable. While it is 0, value bit 0 reads the synchronized pad input, which is delayed by two clock edges. While it is 1, value bit 0 reads 0.
- R5: With bit 25 set and bit 24 clear, a synchronized 0-to-1 transition latches the pad's status bit.
- R6: With bit 26 set and bit 24 clear, a synchronized 1-to-0 transition latches the pad's status bit. Transitions in the opposite direction latch nothing.
- R7: With bit 24 set, the status bit follows the pad level. The active level is high, except when bit 26 is set and bit 25 is clear, in which case it is low. Writing 1 to the bit does not clear it.
- R8: Writing 1 to a latched status bit clears it. Bits written with 0 are left unchanged. If a new qualifying edge arrives in the same cycle as the clear, the bit stays set.
- R9: The status bit of pad n is bit n mod 32 of the word at 0x800 + 4*(n/32). Bits for pads at or above the bank size read 0.
- R10: While the input enable is off (value bit 2 = 1), no edge or level event is recorded.
- R11: irq is the OR of the status bits of those pads that have at least one of bits 26, 25 or 24 set.
- R12: bus_rdata holds the read result exactly one cycle after bus_re and is 0 otherwise. Reads from unmapped addresses return 0, and writes to them change nothing. Unmapped addresses are: pad groups at or above the bank size, status words past the last one, and any address with bits 1:0 not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, one cycle after bus_re |
| pad_in | input | NPADS | Asynchronous pad inputs |
| pad_out | output | NPADS | Pad output levels |
| pad_oe | output | NPADS | Pad output enables, active high |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that bus_re is low whenever it is not in use, so an idle cycle has a defined read value. They also assume that bus_we and bus_re are never high together on the same address. The bench drives every bus and pad input at the falling clock edge and always pulses one enable at a time. It holds each pad level for at least four cycles, so every synchronized transition is seen once. The one deliberate overlap is the clear that races a fresh edge, which the bench times to the cycle the edge reaches the status latch.

// File: rtl/gpad_pkg.sv
package gpad_pkg;
  localparam int ADDR_W    = 12;
  localparam int PAD_IDX_W = 7;
  localparam int WORD_IDX_W = 9;
  localparam int TRIG_FALL = 26;
  localparam int TRIG_RISE = 25;
  localparam int TRIG_LVL  = 24;
  localparam int FSEL_W    = 3;
  localparam int VAL_IEN_N = 2;
  localparam int VAL_OEN_N = 1;
  localparam int VAL_LEVEL = 0;

  typedef enum logic [1:0] {
    REG_CFGA = 2'd0,
    REG_CFGB = 2'd1,
    REG_VAL  = 2'd2,
    REG_DFLT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              fall;
    logic              rise;
    logic              lvl;
    logic [FSEL_W-1:0] fsel;
  } cfga_t;
endpackage

// File: rtl/gpad_sync.sv
module gpad_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/gpad_pad.sv
module gpad_pad
  import gpad_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  reg_sel_e    reg_sel,
  input  logic [31:0] wdata,
  input  logic        clr,
  input  logic        pin_sync,
  output logic        pad_out,
  output logic        pad_oe,
  output logic        stat,
  output logic        armed,
  output logic [31:0] rd_val
);
  cfga_t       cfga_q;
  logic [31:0] cfgb_q;
  logic [31:0] dflt_q;
  logic        ien_n_q;
  logic        oen_n_q;
  logic        level_q;
  logic        prev_q;
  logic        edge_q;

  logic pin_live;
  logic rise_ev;
  logic fall_ev;
  logic edge_set;
  logic act_low;
  logic lvl_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfga_q  <= '0;
      cfgb_q  <= '0;
      dflt_q  <= '0;
      ien_n_q <= 1'b1;
      oen_n_q <= 1'b1;
      level_q <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel)
        REG_CFGA: cfga_q <= '{fall: wdata[TRIG_FALL], rise: wdata[TRIG_RISE],
                              lvl: wdata[TRIG_LVL], fsel: wdata[FSEL_W-1:0]};
        REG_CFGB: cfgb_q <= wdata;
        REG_VAL: begin
          ien_n_q <= wdata[VAL_IEN_N];
          oen_n_q <= wdata[VAL_OEN_N];
          level_q <= wdata[VAL_LEVEL];
        end
        default:  dflt_q <= wdata;
      endcase
    end
  end

  // edge detection against the previous synchronized sample
  assign pin_live = !ien_n_q && pin_sync;
  assign rise_ev  = pin_live && !prev_q;
  assign fall_ev  = !ien_n_q && !pin_sync && prev_q;
  assign edge_set = !cfga_q.lvl &&
                    ((cfga_q.rise && rise_ev) || (cfga_q.fall && fall_ev));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= pin_sync;
      if (edge_set)  edge_q <= 1'b1;
      else if (clr)  edge_q <= 1'b0;
    end
  end

  assign act_low = cfga_q.fall && !cfga_q.rise;
  assign lvl_hit = !ien_n_q && (pin_sync ^ act_low);
  assign stat    = cfga_q.lvl ? lvl_hit : edge_q;
  assign armed   = cfga_q.fall || cfga_q.rise || cfga_q.lvl;
  assign pad_out = level_q;
  assign pad_oe  = !oen_n_q && (cfga_q.fsel == '0);

  always_comb begin
    rd_val = '0;
    case (reg_sel)
      REG_CFGA: begin
        rd_val[TRIG_FALL]    = cfga_q.fall;
        rd_val[TRIG_RISE]    = cfga_q.rise;
        rd_val[TRIG_LVL]     = cfga_q.lvl;
        rd_val[FSEL_W-1:0]   = cfga_q.fsel;
      end
      REG_CFGB: rd_val = cfgb_q;
      REG_VAL: begin
        rd_val[VAL_IEN_N] = ien_n_q;
        rd_val[VAL_OEN_N] = oen_n_q;
        rd_val[VAL_LEVEL] = pin_live;
      end
      default:  rd_val = dflt_q;
    endcase
  end

  // R10: a disabled input never produces a new latched edge
  a_r10_no_event_disabled: assert property (@(posedge clk) disable iff (rst)
    ien_n_q |=> !$rose(edge_q));

  // R8: a clear with no competing edge empties the latch
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr && !edge_set) |=> !edge_q);
endmodule

// File: rtl/gpad_bank.sv
module gpad_bank
  import gpad_pkg::*;
#(
  parameter int NPADS = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic [NPADS-1:0]  pad_in,
  output logic [NPADS-1:0]  pad_out,
  output logic [NPADS-1:0]  pad_oe,
  output logic              irq
);
  localparam int NWORDS = (NPADS + 31) / 32;

  logic [NPADS-1:0]  pin_sync;
  logic [NPADS-1:0]  stat_vec;
  logic [NPADS-1:0]  armed_vec;
  logic [31:0]       pad_rd [NPADS];
  logic [NWORDS*32-1:0] stat_full;

  logic                  aligned;
  logic                  in_stat;
  logic [PAD_IDX_W-1:0]  pad_sel;
  logic [WORD_IDX_W-1:0] word_sel;
  reg_sel_e              reg_sel;
  logic [31:0]           rd_comb;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_stat  = aligned && bus_addr[ADDR_W-1];
  assign pad_sel  = bus_addr[ADDR_W-2:4];
  assign word_sel = bus_addr[ADDR_W-2:2];
  assign reg_sel  = reg_sel_e'(bus_addr[3:2]);

  gpad_sync #(.W(NPADS)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pad_in),
    .d_sync  (pin_sync)
  );

  for (genvar i = 0; i < NPADS; i++) begin : g_pad
    localparam int WIDX = i / 32;
    localparam int BIDX = i % 32;
    logic wr_hit;
    logic clr_hit;

    assign wr_hit  = bus_we && aligned && !bus_addr[ADDR_W-1] &&
                     (pad_sel == PAD_IDX_W'(i));
    assign clr_hit = bus_we && in_stat &&
                     (word_sel == WORD_IDX_W'(WIDX)) && bus_wdata[BIDX];

    gpad_pad u_pad (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_hit),
      .reg_sel  (reg_sel),
      .wdata    (bus_wdata),
      .clr      (clr_hit),
      .pin_sync (pin_sync[i]),
      .pad_out  (pad_out[i]),
      .pad_oe   (pad_oe[i]),
      .stat     (stat_vec[i]),
      .armed    (armed_vec[i]),
      .rd_val   (pad_rd[i])
    );
  end

  always_comb begin
    stat_full = '0;
    stat_full[NPADS-1:0] = stat_vec;
  end

  always_comb begin
    rd_comb = '0;
    if (in_stat) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (word_sel == WORD_IDX_W'(w)) rd_comb = stat_full[w*32 +: 32];
      end
    end else if (aligned) begin
      for (int p = 0; p < NPADS; p++) begin
        if (pad_sel == PAD_IDX_W'(p)) rd_comb = pad_rd[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_re ? rd_comb : '0;
  end

  assign irq = |(stat_vec & armed_vec);

  // R12: with no read in the previous cycle the read port is quiet
  a_r12_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_re) |-> (bus_rdata == '0));

  // R11: the merged interrupt needs at least one armed pad
  a_r11_irq_needs_arm: assert property (@(posedge clk) disable iff (rst)
    irq |-> (armed_vec != '0));
endmodule

// File: tb/gpad_bank_bench.sv
module gpad_bank_bench;
  localparam int NPADS = 44;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [11:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic             bus_we = 1'b0;
  logic             bus_re = 1'b0;
  logic [31:0]      bus_rdata;
  logic [NPADS-1:0] pad_in = '0;
  logic [NPADS-1:0] pad_out;
  logic [NPADS-1:0] pad_oe;
  logic             irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpad_bank #(.NPADS(NPADS)) u_gpad_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  localparam logic [31:0] B_FALL = 32'h0400_0000;
  localparam logic [31:0] B_RISE = 32'h0200_0000;
  localparam logic [31:0] B_LVL  = 32'h0100_0000;

  function automatic logic [11:0] ra(int p, int r);
    return 12'(p * 16 + r * 4);
  endfunction

  function automatic logic [11:0] sa(int w);
    return 12'(12'h800 + w * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(ra(0, 2), d);  chk("R2 value reset", d, 32'h6);
    rd(ra(43, 0), d); chk("R2 cfgA reset", d, 0);
    rd(sa(0), d);     chk("R2 status0 reset", d, 0);
    rd(sa(1), d);     chk("R2 status1 reset", d, 0);
    chk("R2 pad_oe reset", 32'(pad_oe), 0);
    chk("R2 pad_out reset", 32'(pad_out), 0);
    chk("R2 irq reset", 32'(irq), 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(ra(5, 0), 32'hFFFF_FFFF);
    rd(ra(5, 0), d);  chk("R1 cfgA mask", d, 32'h0700_0007);
    wr(ra(5, 1), 32'h1234_5678);
    wr(ra(6, 1), 32'h0000_0001);
    rd(ra(5, 1), d);  chk("R1 cfgB stride", d, 32'h1234_5678);
    wr(ra(43, 3), 32'hA5A5_5A5A);
    rd(ra(43, 3), d); chk("R1 default reg", d, 32'hA5A5_5A5A);
    wr(ra(5, 0), 0);
  endtask

  task automatic t_output();
    wr(ra(7, 2), 32'h1);
    chk("R3 out level", 32'(pad_out[7]), 1);
    chk("R3 oe on", 32'(pad_oe[7]), 1);
    wr(ra(7, 0), 32'h1);
    chk("R3 oe off when fsel!=0", 32'(pad_oe[7]), 0);
    wr(ra(7, 0), 32'h0);
    chk("R3 oe back", 32'(pad_oe[7]), 1);
    wr(ra(7, 2), 32'h6);
    chk("R3 oe disabled", 32'(pad_oe[7]), 0);
    chk("R3 out low", 32'(pad_out[7]), 0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    wr(ra(9, 2), 32'h2);
    @(negedge clk); pad_in[9] = 1'b1;
    settle();
    rd(ra(9, 2), d); chk("R4 input sampled", d, 32'h3);
    wr(ra(9, 2), 32'h6);
    rd(ra(9, 2), d); chk("R4 input masked", d, 32'h6);
    pad_in[9] = 1'b0;
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(ra(40, 0), B_RISE);
    wr(ra(40, 2), 32'h2);
    @(negedge clk); pad_in[40] = 1'b1;
    settle();
    rd(sa(1), d);  chk("R5 R9 rise latched word1 bit8", d, 32'h100);
    chk("R11 irq on", 32'(irq), 1);
    @(negedge clk); pad_in[40] = 1'b0;
    settle();
    rd(sa(1), d);  chk("R5 stays latched after fall", d, 32'h100);
    wr(sa(1), 32'h0000_0000);
    rd(sa(1), d);  chk("R8 zero write keeps bit", d, 32'h100);
    wr(sa(1), 32'hFFFF_FFFF);
    rd(sa(1), d);  chk("R8 W1C clears", d, 0);
    chk("R11 irq off", 32'(irq), 0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(ra(3, 0), B_FALL);
    wr(ra(3, 2), 32'h2);
    @(negedge clk); pad_in[3] = 1'b1;
    settle();
    rd(sa(0), d);  chk("R6 rise ignored", d, 0);
    @(negedge clk); pad_in[3] = 1'b0;
    settle();
    rd(sa(0), d);  chk("R6 fall latched", d, 32'h8);
    wr(sa(0), 32'h8);
    rd(sa(0), d);  chk("R6 cleared", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(ra(3, 0), B_LVL | B_RISE);
    @(negedge clk); pad_in[3] = 1'b1;
    settle();
    rd(sa(0), d);  chk("R7 high level active", d, 32'h8);
    wr(sa(0), 32'h8);
    rd(sa(0), d);  chk("R7 W1C no effect", d, 32'h8);
    @(negedge clk); pad_in[3] = 1'b0;
    settle();
    rd(sa(0), d);  chk("R7 follows pad low", d, 0);
    wr(ra(3, 0), B_LVL | B_FALL);
    rd(sa(0), d);  chk("R7 low level active", d, 32'h8);
    @(negedge clk); pad_in[3] = 1'b1;
    settle();
    rd(sa(0), d);  chk("R7 low level released", d, 0);
    wr(ra(3, 0), 0);
    pad_in[3] = 1'b0;
    settle();
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(ra(40, 0), B_RISE);
    @(negedge clk); pad_in[40] = 1'b1;
    settle();
    @(negedge clk); pad_in[40] = 1'b0;
    settle();
    rd(sa(1), d);  chk("R8 race precondition", d, 32'h100);
    @(negedge clk); pad_in[40] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = sa(1); bus_wdata = 32'h100; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(sa(1), d);  chk("R8 edge beats clear", d, 32'h100);
    wr(ra(40, 0), 0);
    rd(sa(1), d);  chk("R11 status kept when disarmed", d, 32'h100);
    chk("R11 irq masked when disarmed", 32'(irq), 0);
    wr(sa(1), 32'h100);
    pad_in[40] = 1'b0;
    rd(sa(1), d);  chk("R8 cleared after race", d, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(ra(12, 0), B_RISE | B_FALL);
    @(negedge clk); pad_in[12] = 1'b1;
    settle();
    @(negedge clk); pad_in[12] = 1'b0;
    settle();
    rd(sa(0), d);  chk("R10 no event while disabled", d, 0);
    chk("R10 irq quiet", 32'(irq), 0);
    wr(ra(12, 3), 32'h0);
    wr(ra(12, 0), B_LVL | B_FALL);
    rd(sa(0), d);  chk("R10 level masked while disabled", d, 0);
    wr(ra(12, 0), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(ra(44, 1), 32'hDEAD_BEEF);
    rd(ra(44, 1), d);  chk("R12 pad past bank", d, 0);
    rd(sa(2), d);      chk("R12 status past last word", d, 0);
    wr(12'(ra(5, 1) + 1), 32'h0);
    rd(12'(ra(5, 1) + 1), d); chk("R12 misaligned read", d, 0);
    rd(ra(5, 1), d);   chk("R12 misaligned write ignored", d, 32'h1234_5678);
    @(negedge clk);
    chk("R12 idle rdata zero", bus_rdata, 0);
    wr(ra(41, 0), B_LVL);
    wr(ra(41, 2), 32'h2);
    @(negedge clk); pad_in[41] = 1'b1;
    settle();
    rd(sa(1), d);      chk("R9 tail bits zero", d, 32'h200);
    wr(ra(41, 0), 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_output();
    t_input();
    t_rise();
    t_fall();
    t_level();
    t_race();
    t_disabled();
    t_unmapped();
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule